// File: doc/BRIEF.md
# Breakpoint Acknowledge Bus Sequencer

This block sits on the processor side of an asynchronous, dynamically sized bus. When the core decodes a breakpoint, it passes a 3-bit breakpoint number to the sequencer with a one-cycle request. The sequencer then runs a dedicated read in CPU address space. It drives the function code for CPU space, a type code of zero, the breakpoint number, a word-size request, and the address and data strobes. It then waits for the slave to end the transfer.

A slave can end the transfer in one of two ways. If it returns data, the returned 16-bit word is handed to the pipeline as a one-cycle replacement instruction. If it answers with a bus error, the sequencer raises a one-cycle illegal-instruction request instead. A slave that acknowledges as an 8-bit port supplies only the upper byte. In that case the sequencer runs a second byte cycle at the next address to fetch the lower byte, and then joins the two bytes. The sequencer does not return to idle until the slave has removed its termination signals.

Top module: `bkpt_ack_seq`

## Requirements
- R1: After reset, both strobes are negated (high), `seq_busy` is low, and neither `insn_valid` nor `illegal_exc` is asserted.
- R2: A `bkpt_req` seen while idle starts a bus cycle one clock later. During every strobed cycle, `bus_rw` is 1 (read) and `bus_fc` is 3'b111 (CPU space). On the first cycle, `bus_siz` is 2'b10 (word), and `bus_as_n` and `bus_ds_n` are driven low.
- R3: While a strobe is asserted, `bus_addr` holds zero in every bit except two places: bits 4:2 carry the breakpoint number, and bit 0 is 1 on the second byte cycle. Bits 19:16 (the type code) are therefore zero. The address does not change while the strobe is asserted.
- R4: The strobes are negated in the clock after an acknowledge or a bus error is sampled. They stay negated until both `term_ack` and `bus_err` have returned to zero.
- R5: `term_ack` encodes the port width of the acknowledging slave: 2'b11 means a 32-bit port, 2'b10 a 16-bit port, and 2'b01 an 8-bit port. For a 32-bit or 16-bit acknowledge, the word taken is `bus_din[31:16]`. It appears on `insn_word` during a one-cycle `insn_valid` pulse after the termination is removed.
- R6: After an 8-bit acknowledge, a second cycle runs with `bus_siz` = 2'b01 and the address incremented by one. The first cycle's byte, taken from `bus_din[31:24]`, becomes the high byte of the word. The second cycle's byte, from the same lane, becomes the low byte.
- R7: A bus error in either cycle produces a one-cycle `illegal_exc` pulse and no `insn_valid`. When a bus error and an acknowledge are seen together, the bus error takes priority.
- R8: Each accepted request yields exactly one of `insn_valid` or `illegal_exc`. A `bkpt_req` that arrives while `seq_busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bkpt_req | input | 1 | Breakpoint request from the core |
| bkpt_num | input | 3 | Breakpoint number |
| seq_busy | output | 1 | Sequencer is not idle |
| bus_addr | output | ADDR_W | Address bus |
| bus_fc | output | 3 | Function code |
| bus_siz | output | 2 | Transfer size request |
| bus_rw | output | 1 | 1 = read |
| bus_as_n | output | 1 | Address strobe, active low |
| bus_ds_n | output | 1 | Data strobe, active low |
| bus_din | input | DATA_W | Read data from the slave |
| term_ack | input | 2 | Acknowledge and port width |
| bus_err | input | 1 | Bus error termination |
| insn_valid | output | 1 | Replacement instruction pulse |
| insn_word | output | 16 | Replacement instruction word |
| illegal_exc | output | 1 | Illegal-instruction request pulse |

## Verification
The bench drives each corner case and compares the outcome against a scoreboard:
- **Byte-port path:** a design that skipped the second cycle would deliver a half-empty word. One that reversed the byte order would deliver the bytes swapped.
- **Bus error on the second byte cycle:** a design that ignored this error would wrongly deliver a word.
- **Simultaneous bus error and acknowledge:** a design that gave the acknowledge priority would inject an opcode instead of trapping.
- **Decoy lanes:** the slave fills the low data bits with decoy values, so a design that read the wrong lane would return a wrong word.
- **Wait states:** the slave adds wait states, testing that the strobes are held until termination.
- **Request during busy:** a request issued in the middle of a cycle must produce neither a second result nor a change of address.

// File: rtl/bkpt_seq_pkg.sv
package bkpt_seq_pkg;

    localparam logic [2:0] FC_CPU_SPACE  = 3'b111;
    localparam logic [3:0] CPU_TYPE_BKPT = 4'h0;
    localparam logic [1:0] SIZ_WORD      = 2'b10;
    localparam logic [1:0] SIZ_BYTE      = 2'b01;
    localparam logic [1:0] ACK_BYTE_PORT = 2'b01;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_STROBE  = 2'd1,
        ST_RELEASE = 2'd2
    } seq_state_e;

    typedef struct packed {
        seq_state_e  state;
        logic [2:0]  num;
        logic        second;
        logic        need2;
        logic        err;
        logic [7:0]  hi_byte;
        logic [15:0] word;
        logic        valid;
        logic        exc;
    } seq_regs_t;

endpackage

// File: rtl/bkpt_addr_gen.sv
module bkpt_addr_gen
    import bkpt_seq_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [2:0]        num,
    input  logic              byte_sel,
    output logic [ADDR_W-1:0] addr
);
    localparam int TYPE_LSB = 16;
    localparam int NUM_LSB  = 2;

    always_comb begin
        addr = '0;
        addr[TYPE_LSB +: 4] = CPU_TYPE_BKPT;
        addr[NUM_LSB +: 3]  = num;
        addr[0]             = byte_sel;
    end

    initial begin
        if (ADDR_W < 20) $error("ADDR_W too small for the type field");
    end
endmodule

// File: rtl/bkpt_lane_pick.sv
module bkpt_lane_pick #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] din,
    output logic [15:0]       word_lane,
    output logic [7:0]        byte_lane
);
    localparam int TOP = DATA_W - 1;

    always_comb begin
        word_lane = din[TOP -: 16];
        byte_lane = din[TOP -: 8];
    end
endmodule

// File: rtl/bkpt_ack_seq.sv
module bkpt_ack_seq
    import bkpt_seq_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bkpt_req,
    input  logic [2:0]        bkpt_num,
    output logic              seq_busy,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [2:0]        bus_fc,
    output logic [1:0]        bus_siz,
    output logic              bus_rw,
    output logic              bus_as_n,
    output logic              bus_ds_n,
    input  logic [DATA_W-1:0] bus_din,
    input  logic [1:0]        term_ack,
    input  logic              bus_err,
    output logic              insn_valid,
    output logic [15:0]       insn_word,
    output logic              illegal_exc
);
    seq_regs_t   r_q, r_d;
    logic [15:0] word_lane;
    logic [7:0]  byte_lane;
    logic        term_any;

    bkpt_lane_pick #(.DATA_W(DATA_W)) u_lane (
        .din       (bus_din),
        .word_lane (word_lane),
        .byte_lane (byte_lane)
    );

    bkpt_addr_gen #(.ADDR_W(ADDR_W)) u_addr (
        .num      (r_q.num),
        .byte_sel (r_q.second),
        .addr     (bus_addr)
    );

    assign term_any = bus_err || (term_ack != 2'b00);

    always_comb begin
        r_d       = r_q;
        r_d.valid = 1'b0;
        r_d.exc   = 1'b0;
        case (r_q.state)
            ST_IDLE: begin
                if (bkpt_req) begin
                    r_d.state  = ST_STROBE;
                    r_d.num    = bkpt_num;
                    r_d.second = 1'b0;
                    r_d.need2  = 1'b0;
                    r_d.err    = 1'b0;
                end
            end
            ST_STROBE: begin
                if (bus_err) begin
                    r_d.err   = 1'b1;
                    r_d.state = ST_RELEASE;
                end else if (term_ack != 2'b00) begin
                    if (r_q.second) begin
                        r_d.word  = {r_q.hi_byte, byte_lane};
                        r_d.need2 = 1'b0;
                    end else if (term_ack == ACK_BYTE_PORT) begin
                        r_d.hi_byte = byte_lane;
                        r_d.need2   = 1'b1;
                    end else begin
                        r_d.word = word_lane;
                    end
                    r_d.state = ST_RELEASE;
                end
            end
            ST_RELEASE: begin
                if (!term_any) begin
                    if (r_q.need2 && !r_q.err) begin
                        r_d.state  = ST_STROBE;
                        r_d.second = 1'b1;
                        r_d.need2  = 1'b0;
                    end else begin
                        r_d.state = ST_IDLE;
                        r_d.valid = !r_q.err;
                        r_d.exc   = r_q.err;
                    end
                end
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{state: ST_IDLE, num: 3'd0, second: 1'b0, need2: 1'b0,
                     err: 1'b0, hi_byte: 8'h00, word: 16'h0000,
                     valid: 1'b0, exc: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign seq_busy    = (r_q.state != ST_IDLE);
    assign bus_as_n    = (r_q.state != ST_STROBE);
    assign bus_ds_n    = (r_q.state != ST_STROBE);
    assign bus_rw      = 1'b1;
    assign bus_fc      = (r_q.state == ST_STROBE) ? FC_CPU_SPACE : 3'b000;
    assign bus_siz     = r_q.second ? SIZ_BYTE : SIZ_WORD;
    assign insn_valid  = r_q.valid;
    assign insn_word   = r_q.word;
    assign illegal_exc = r_q.exc;

    AST_START_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!seq_busy && bkpt_req) |=> (!bus_as_n && !bus_ds_n && bus_siz == SIZ_WORD)); // R2
    AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_as_n && $past(!bus_as_n)) |-> $stable(bus_addr)); // R3
    AST_STROBE_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_as_n && term_any) |=> bus_as_n); // R4
    AST_HOLD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_as_n && seq_busy && term_any) |=> bus_as_n); // R4
    AST_PULSE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (insn_valid || illegal_exc) |=> !(insn_valid || illegal_exc)); // R5
    AST_ONE_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        !(insn_valid && illegal_exc)); // R8
    AST_BERR_TRAPS: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_as_n && bus_err) |=> !insn_valid); // R7
endmodule

// File: tb/bkpt_ack_seq_bench.sv
module bkpt_ack_seq_bench;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 32;
    localparam int DATA_W = 32;

    typedef struct {
        int          mode;
        logic [2:0]  num;
        logic [15:0] word;
        int          ws;
    } slave_cfg_t;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bkpt_req = 1'b0;
    logic [2:0]        bkpt_num = 3'd0;
    logic              seq_busy;
    logic [ADDR_W-1:0] bus_addr;
    logic [2:0]        bus_fc;
    logic [1:0]        bus_siz;
    logic              bus_rw, bus_as_n, bus_ds_n;
    logic [DATA_W-1:0] bus_din = '0;
    logic [1:0]        term_ack = 2'b00;
    logic              bus_err = 1'b0;
    logic              insn_valid, illegal_exc;
    logic [15:0]       insn_word;

    int checks = 0;
    int failures = 0;
    int issued = 0;
    int received = 0;
    bit done = 1'b0;

    slave_cfg_t  sq[$];
    logic [16:0] exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    bkpt_ack_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_bkpt_ack_seq (
        .clk(clk), .rst_n(rst_n), .bkpt_req(bkpt_req), .bkpt_num(bkpt_num),
        .seq_busy(seq_busy), .bus_addr(bus_addr), .bus_fc(bus_fc),
        .bus_siz(bus_siz), .bus_rw(bus_rw), .bus_as_n(bus_as_n),
        .bus_ds_n(bus_ds_n), .bus_din(bus_din), .term_ack(term_ack),
        .bus_err(bus_err), .insn_valid(insn_valid), .insn_word(insn_word),
        .illegal_exc(illegal_exc)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    // mode: 0 32-bit port, 1 16-bit port, 2 byte port, 3 bus error,
    //       4 byte port with bus error on second cycle, 5 bus error with ack
    task automatic do_req(input int mode, input logic [2:0] num,
                          input logic [15:0] word, input int ws);
        slave_cfg_t c;
        @(negedge clk);
        while (seq_busy) @(negedge clk);
        c.mode = mode; c.num = num; c.word = word; c.ws = ws;
        sq.push_back(c);
        exp_q.push_back((mode >= 3) ? {1'b1, 16'h0000} : {1'b0, word});
        issued++;
        bkpt_req = 1'b1;
        bkpt_num = num;
        @(negedge clk);
        bkpt_req = 1'b0;
        chk(!bus_as_n && !bus_ds_n, "R2 strobes after request",
            {30'd0, bus_as_n, bus_ds_n}, 32'd0);
    endtask

    task automatic poke_busy(input logic [2:0] num);
        @(negedge clk);
        chk(seq_busy, "R8 busy during poke", {31'd0, seq_busy}, 32'd1);
        bkpt_req = 1'b1;
        bkpt_num = num;
        @(negedge clk);
        bkpt_req = 1'b0;
    endtask

    // slave model
    initial begin
        slave_cfg_t cur;
        cur.mode = 0; cur.num = 3'd0; cur.word = 16'h0; cur.ws = 0;
        forever begin
            @(negedge clk);
            if (rst_n && !bus_as_n) begin
                if (bus_addr[0] == 1'b0) begin
                    if (sq.size() == 0) begin
                        chk(1'b0, "R8 unexpected bus cycle", bus_addr, 32'd0);
                    end else begin
                        cur = sq.pop_front();
                    end
                end
                chk(bus_rw == 1'b1, "R2 read direction", {31'd0, bus_rw}, 32'd1);
                chk(bus_fc == 3'b111, "R2 cpu space code", {29'd0, bus_fc}, 32'd7);
                chk(bus_siz == (bus_addr[0] ? 2'b01 : 2'b10), "R6 size request",
                    {30'd0, bus_siz}, bus_addr[0] ? 32'd1 : 32'd2);
                chk(bus_addr == ({27'd0, cur.num, 2'b00} | {31'd0, bus_addr[0]}),
                    "R3 address", bus_addr, {27'd0, cur.num, 2'b00});
                repeat (cur.ws) @(negedge clk);
                if (!bus_addr[0]) begin
                    case (cur.mode)
                        0: begin term_ack = 2'b11; bus_din = {cur.word, 16'hDEAD}; end
                        1: begin term_ack = 2'b10; bus_din = {cur.word, 16'hBEEF}; end
                        2, 4: begin term_ack = 2'b01; bus_din = {cur.word[15:8], 24'hA5C3E1}; end
                        3: begin bus_err = 1'b1; bus_din = 32'h1234_5678; end
                        default: begin bus_err = 1'b1; term_ack = 2'b10;
                                        bus_din = {cur.word, 16'h0F0F}; end
                    endcase
                end else begin
                    if (cur.mode == 4) begin
                        bus_err = 1'b1;
                    end else begin
                        term_ack = 2'b01;
                        bus_din = {cur.word[7:0], 24'h3C96F0};
                    end
                end
                do @(negedge clk); while (!bus_as_n);
                term_ack = 2'b00;
                bus_err = 1'b0;
                bus_din = 32'hFFFF_FFFF;
            end
        end
    end

    // monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n && (insn_valid || illegal_exc)) begin
            received++;
            if (exp_q.size() == 0) begin
                chk(1'b0, "R8 result without request", {15'd0, illegal_exc, insn_word}, 32'd0);
            end else begin
                logic [16:0] e;
                e = exp_q.pop_front();
                if (e[16]) begin
                    chk(illegal_exc && !insn_valid, "R7 illegal exception",
                        {30'd0, insn_valid, illegal_exc}, 32'd1);
                end else begin
                    chk(insn_valid && !illegal_exc, "R5 word delivered",
                        {30'd0, insn_valid, illegal_exc}, 32'd2);
                    chk(insn_word == e[15:0], "R6 word value",
                        {16'd0, insn_word}, {16'd0, e[15:0]});
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        chk(1'b0, "R8 watchdog expired", 32'd0, 32'd1);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(bus_as_n && bus_ds_n && !seq_busy && !insn_valid && !illegal_exc,
            "R1 reset state",
            {27'd0, bus_as_n, bus_ds_n, seq_busy, insn_valid, illegal_exc}, 32'h18);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(bus_as_n && !seq_busy, "R1 idle after reset",
            {30'd0, bus_as_n, seq_busy}, 32'd2);

        do_req(0, 3'd3, 16'h4E71, 0);   // R5 32-bit port
        do_req(1, 3'd5, 16'hA1B2, 2);   // R5 16-bit port, wait states
        do_req(2, 3'd1, 16'hC3D4, 1);   // R6 byte port
        do_req(3, 3'd6, 16'h0000, 0);   // R7 bus error
        do_req(4, 3'd2, 16'h5566, 0);   // R7 bus error on byte cycle
        do_req(5, 3'd0, 16'h7788, 1);   // R7 error beats ack
        do_req(1, 3'd4, 16'h9ABC, 4);   // R8 request during busy ignored
        poke_busy(3'd7);
        do_req(0, 3'd7, 16'hFEDC, 0);   // R3 highest number
        do_req(2, 3'd7, 16'h0102, 3);   // R6 byte port again

        @(negedge clk);
        while (seq_busy) @(negedge clk);
        repeat (3) @(negedge clk);
        chk(received == issued, "R8 one result per request", received, issued);
        chk(exp_q.size() == 0 && sq.size() == 0, "R8 nothing pending",
            exp_q.size(), 32'd0);
        chk(bus_as_n && !insn_valid && !illegal_exc, "R4 quiet at end",
            {29'd0, bus_as_n, insn_valid, illegal_exc}, 32'd4);
        finish_run();
    end
endmodule